// File: doc/BRIEF.md
# I2C Register Target With Persistent Pointer

This block is an I2C target that gives an external master read and write access to a bank of 256 eight-bit registers inside the chip. The system clock samples SCL and SDA, and the block finds start, repeated-start and stop conditions on the synchronized lines. It answers to one 7-bit device address. The upper five bits of that address are fixed at 10010b, and the lower two bits come from a pair of strap pins.

A write-direction transaction loads an 8-bit register pointer. Any further bytes in the same transaction are written to the register that the pointer selects. The pointer does not advance, and it survives stop and repeated-start conditions. A read-direction transaction returns the register the pointer selects, so a master can re-read the last addressed register without sending its address again. The block never drives SCL and never stretches the clock. It pulls SDA low through an active-high output enable, only for its acknowledge bits and for the zero bits of read data.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, `sda_oe_o` is low, every register holds 0x00 and the pointer is 0x00. A read with no pointer written first returns 0x00.
- R2: The device address is {10010b, `strap_i`[1:0]}. With `strap_i`=11b the target answers 0x4B, and with `strap_i`=01b it answers 0x49 and not 0x4B.
- R3: An address byte whose upper seven bits do not match gets no acknowledge. The target then keeps SDA released and ignores every later bit until the next start, so no register or pointer changes.
- R4: All bytes travel MSB first. The eighth bit of the address byte is the direction: 0 means write and 1 means read.
- R5: A matching write-direction address is acknowledged. The byte that follows it is acknowledged and becomes the register pointer.
- R6: In a write transaction, each byte after the pointer byte is acknowledged and stored in the register the pointer selects. The pointer does not change, so the last such byte wins.
- R7: The pointer keeps its value across stop and repeated start. A later read transaction with no pointer byte returns the register the pointer selects, and it does so every time.
- R8: A read-direction address is acknowledged, and the target then sends the eight bits of the selected register. For example, register 0x6D holding 0x49 reads back as 0x49.
- R9: `sda_oe_o` changes only while SCL is low, except that start and stop release it. It is never high while the master drives an address, pointer, data or acknowledge bit.
- R10: A start or repeated start in the middle of a byte abandons that byte. A partly received data byte is not written, and the target goes back to receiving an address.
- R11: A stop returns the target to idle with SDA released. SCL pulses that follow, with no start, get no acknowledge.
- R12: After a read byte, the master may issue a repeated start that leads to a write, to a pointer change, or to another read, and each of these works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Strap pins that set the low two device-address bits |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The stored values and pointers are chosen so that MSB-first order can be told apart from reversed order. The bench reads the values 0x49, 0x5E and 0x17, which bit reversal would turn into 0x92, 0x7A and 0xE8. It writes two data bytes in a row to a single pointer, which separates a pointer that holds from one that auto-increments. It runs reads with no pointer byte, both right after a stop and right after a repeated start, to show that the pointer survives. It also runs three kinds of broken frame: a mismatched address, a strap change, and a byte cut short by a repeated start or by a stop. After each of these it reads the touched register back through the bus, to show that no stray write or pointer load happened.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   // Protocol phases of the target engine
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_REG,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_WAIT
   } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   // Bus lines idle high, so every stage resets to 1
   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= 1'b1;
         else        chain <= line_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], line_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("i2c_reg_file: AW out of supported range");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_lvl,
   input  logic          start_evt,
   input  logic          stop_evt,
   input  logic [DW-2:0] dev_addr,
   input  logic [DW-1:0] rdata,
   output logic          wr_en,
   output logic [DW-1:0] wr_data,
   output logic [DW-1:0] ptr,
   output logic          sda_oe
);

   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] FULL = CW'(DW);

   tgt_state_e    state, after_ack;
   logic [CW-1:0] cnt;
   logic [DW-1:0] rx_sh, tx_sh;
   logic          byte_done;

   assign byte_done = scl_fall && (cnt == FULL);
   assign wr_en     = !start_evt && !stop_evt && (state == ST_WDATA) && byte_done;
   assign wr_data   = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         sda_oe    <= 1'b0;
      end else if (start_evt) begin
         // start and repeated start outrank any bit activity
         state  <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (stop_evt) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_REG, ST_WDATA: begin
               if (scl_rise && cnt != FULL) begin
                  rx_sh <= {rx_sh[DW-2:0], sda_lvl};
                  cnt   <= cnt + 1'b1;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (state == ST_ADDR) begin
                     if (rx_sh[DW-1:1] == dev_addr) begin
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= rx_sh[0] ? ST_TX : ST_REG;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end else begin
                     if (state == ST_REG) ptr <= rx_sh;
                     sda_oe    <= 1'b1;
                     state     <= ST_ACK;
                     after_ack <= ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  if (after_ack == ST_TX) begin
                     tx_sh  <= rdata;
                     sda_oe <= ~rdata[DW-1];
                     cnt    <= CW'(1);
                  end else begin
                     sda_oe <= 1'b0;
                  end
                  state <= after_ack;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt == FULL) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WAIT;
                  end else begin
                     tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                     sda_oe <= ~tx_sh[DW-2];
                     cnt    <= cnt + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter int               DATA_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               PREFIX_W    = 5,
   parameter int               STRAP_W     = 2,
   parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_oe_o
);

   if (PREFIX_W + STRAP_W != DATA_W - 1) begin : g_bad_addr
      $error("i2c_regbank_target: prefix plus strap must fill the address");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_evt, stop_evt;
   logic wr_en;
   logic [DATA_W-1:0] wr_data, ptr, rdata;
   logic [DATA_W-2:0] dev_addr;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   assign start_evt = scl_lvl & sda_fall;
   assign stop_evt  = scl_lvl & sda_rise;
   assign dev_addr  = {ADDR_PREFIX, strap_i};

   i2c_tgt_engine #(.DW(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .dev_addr(dev_addr), .rdata(rdata),
      .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr), .sda_oe(sda_oe_o)
   );

   i2c_reg_file #(.AW(DATA_W), .DW(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en), .waddr(ptr), .wdata(wr_data),
      .raddr(ptr), .rdata(rdata)
   );

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_lvl,
   input logic             start_evt,
   input logic             stop_evt,
   input logic             sda_oe_o,
   input logic             wr_en,
   input logic [PTR_W-1:0] ptr
);

   // R9
   oe_still_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && !start_evt && !stop_evt) |=> $stable(sda_oe_o));

   // R10
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !sda_oe_o);

   // R11
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe_o);

   // R6
   write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> sda_oe_o);

   // R7
   ptr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt || stop_evt) |=> $stable(ptr));

endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.PTR_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
   .start_evt(start_evt), .stop_evt(stop_evt),
   .sda_oe_o(sda_oe_o), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/sim_i2c_regbank_target.sv
module sim_i2c_regbank_target;

   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b11;
   logic       sda_oe;
   logic       sda_bus;
   int         checks = 0;
   int         fails = 0;
   int         oe_viol = 0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_regbank_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .strap_i(strap), .sda_oe_o(sda_oe)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      if (sda_oe) oe_viol++;
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_bus;
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic write_byte(input logic [7:0] d, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(a);
      ack = !a;
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
      send_bit(!mack);
   endtask

   // full pointer-then-read sequence via repeated start
   task automatic read_reg(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] d);
      logic a;
      bus_start();
      write_byte({dev, 1'b0}, a);
      write_byte(ra, a);
      bus_start();
      write_byte({dev, 1'b1}, a);
      read_byte(1'b0, d);
      bus_stop();
   endtask

   task automatic write_reg(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] v);
      logic a;
      bus_start();
      write_byte({dev, 1'b0}, a);
      write_byte(ra, a);
      write_byte(v, a);
      bus_stop();
   endtask

   task automatic t_reset();
      logic a;
      logic [7:0] d;
      check("R1 oe after reset", sda_oe, 0);
      bus_start();
      write_byte({7'h4B, 1'b1}, a);
      check("R2 ack for 0x4B read", a, 1);
      read_byte(1'b0, d);
      check("R1 bare read of reset pointer", d, 8'h00);
      bus_stop();
   endtask

   task automatic t_write_read();
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      check("R5 ack write address", a, 1);
      write_byte(8'h6D, a);
      check("R5 ack pointer byte", a, 1);
      write_byte(8'h49, a);
      check("R6 ack data byte", a, 1);
      bus_stop();
      read_reg(7'h4B, 8'h6D, d);
      check("R8 read 0x6D after Sr", d, 8'h49);
      write_reg(7'h4B, 8'h21, 8'h5E);
      read_reg(7'h4B, 8'h21, d);
      check("R4 MSB-first 0x5E", d, 8'h5E);
   endtask

   task automatic t_multi();
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      write_byte(8'h10, a);
      write_byte(8'h17, a);
      write_byte(8'h5E, a);
      check("R6 ack second data byte", a, 1);
      bus_stop();
      read_reg(7'h4B, 8'h10, d);
      check("R6 last byte wins", d, 8'h5E);
      read_reg(7'h4B, 8'h11, d);
      check("R6 next register untouched", d, 8'h00);
   endtask

   task automatic t_persist();
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      write_byte(8'h6D, a);
      bus_stop();
      bus_start();
      write_byte({7'h4B, 1'b1}, a);
      read_byte(1'b1, d);
      check("R7 bare read after stop", d, 8'h49);
      bus_start();
      write_byte({7'h4B, 1'b1}, a);
      read_byte(1'b0, d);
      check("R7 re-read after Sr", d, 8'h49);
      bus_stop();
   endtask

   task automatic t_nomatch();
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte({7'h4A, 1'b0}, a);
      check("R3 no ack wrong address", a, 0);
      write_byte(8'h6D, a);
      check("R3 no ack later byte", a, 0);
      write_byte(8'h00, a);
      bus_stop();
      read_reg(7'h4B, 8'h6D, d);
      check("R3 register unchanged", d, 8'h49);
      strap = 2'b01;
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      check("R2 0x4B rejected with strap 01", a, 0);
      bus_stop();
      bus_start();
      write_byte({7'h49, 1'b0}, a);
      check("R2 0x49 accepted with strap 01", a, 1);
      write_byte(8'h20, a);
      write_byte(8'h17, a);
      bus_stop();
      read_reg(7'h49, 8'h20, d);
      check("R2 access through 0x49", d, 8'h17);
      strap = 2'b11;
   endtask

   task automatic t_abort();
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      write_byte(8'h6D, a);
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      bus_start();
      write_byte({7'h4B, 1'b1}, a);
      check("R10 address after mid-byte Sr", a, 1);
      read_byte(1'b0, d);
      check("R10 partial byte not written", d, 8'h49);
      bus_stop();
   endtask

   task automatic t_stop_idle();
      logic a;
      logic [7:0] d;
      write_byte({7'h4B, 1'b0}, a);
      check("R11 no ack without start", a, 0);
      bus_stop();
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      write_byte(8'h6D, a);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      bus_stop();
      read_reg(7'h4B, 8'h6D, d);
      check("R11 stop mid-byte drops write", d, 8'h49);
   endtask

   task automatic t_mixed();
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      write_byte(8'h30, a);
      bus_start();
      write_byte({7'h4B, 1'b1}, a);
      read_byte(1'b1, d);
      check("R12 first read of 0x30", d, 8'h00);
      bus_start();
      write_byte({7'h4B, 1'b0}, a);
      check("R12 write after read via Sr", a, 1);
      write_byte(8'h30, a);
      write_byte(8'h17, a);
      bus_start();
      write_byte({7'h4B, 1'b1}, a);
      read_byte(1'b0, d);
      check("R12 read back after Sr write", d, 8'h17);
      bus_stop();
      check("R9 no drive during master bits", oe_viol, 0);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_read();
      t_multi();
      t_persist();
      t_nomatch();
      t_abort();
      t_stop_idle();
      t_mixed();
      repeat (10) @(negedge clk);
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
   end

endmodule